// File: doc/BRIEF.md
# Dual-Modulus Phase Accumulator

This block is the phase engine of a direct digital synthesiser. It produces the coarse phase word for a downstream sine/cosine generator and can step by fractions of a cycle whose denominator is not a power of two. The per-clock phase step has two parts. A 20-bit coarse step is added to a 20-bit coarse accumulator. A 12-bit fine step is added to a 12-bit fine accumulator. The fine accumulator's wrap point is pulled in from 4096 to 4096 minus the modulo input. Each wrap of the fine accumulator adds a carry of one into the coarse accumulator.

Together the coarse and fine steps make one 32-bit word, coarse in the upper 20 bits. A 32-bit host can therefore change the frequency with a single write. With the modulo input at zero, the two accumulators together act as a plain 32-bit binary accumulator. With a suitable modulo, the synthesiser lands exactly on rational frequencies such as 7/33, 8/11 or 9/13 of the clock, and its phase never drifts over time.

Top module: `dual_mod_phase_acc`

## Requirements
- R1: A synchronous active-high reset clears both the coarse phase and the fine accumulator to zero, so `phase` reads 0 after the first clock edge with `reset` high.
- R2: With `modulo` at 0, after n clock edges from reset with a constant step word W = {stepCoarse, stepFine}, `phase` equals bits 31..12 of (n·W mod 2^32).
- R3: When the fine sum (fine accumulator + `stepFine`) reaches 4096 or more, the fine accumulator takes that sum minus 4096 plus `modulo` (kept to 12 bits), and the coarse phase gains one extra count on the same edge. Otherwise the fine accumulator takes the sum, and the coarse phase gains exactly `stepCoarse`.
- R4: The coarse phase wraps modulo 2^20.
- R5: With a step and modulo that encode p/q of a cycle (7/33, 8/11, 9/13), `phase` repeats exactly every q clocks once the fine accumulator has entered its range.
- R6: Changing `stepCoarse`, `stepFine` or `modulo` while running takes effect on the next clock edge and does not clear the accumulated phase.
- R7: `phase` is a registered output with one clock of latency. The first edge after reset with step inputs applied gives `phase` = `stepCoarse` when no fine wrap occurs.
- R8: `reset` takes priority over stepping on the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| reset | input | 1 | Synchronous reset, active high |
| stepCoarse | input | 20 | Coarse phase increment per clock |
| stepFine | input | 12 | Fine phase increment per clock |
| modulo | input | 12 | Amount by which the fine wrap point is pulled below 4096 |
| phase | output | 20 | Registered coarse phase word |

## Verification
The coarse step and the fine-wrap carry meet in the same cycle whenever the fine sum crosses its wrap point. That cycle decides whether the coarse phase advances by the step or by the step plus one. Such cycles are provoked with large fine steps, with nonzero moduli, and with the three rational configurations, where carries recur at a fixed cadence. A behavioural reference model tracks both accumulators as integers and compares the phase on every clock. Separate checks test exact return after q clocks and a closed-form 32-bit product with the modulo at zero.

// File: rtl/phase_acc_pkg.sv
package phase_acc_pkg;
  // Strobes from the fine (control) stage to the coarse (datapath) stage
  typedef struct packed {
    logic clear;  // synchronous clear of the coarse phase
    logic carry;  // fine accumulator wrapped on this edge
  } acc_strobe_t;
endpackage

// File: rtl/phase_acc_fine.sv
module phase_acc_fine
  import phase_acc_pkg::*;
#(
  parameter int FINE_W = 12
) (
  input  logic              clk,
  input  logic              reset,
  input  logic [FINE_W-1:0] stepFine,
  input  logic [FINE_W-1:0] modulo,
  output acc_strobe_t       strobe,
  output logic [FINE_W-1:0] fineAcc
);
  logic [FINE_W:0]   fineSum;
  logic              wrap;
  logic [FINE_W-1:0] fineNext;

  always_comb begin
    fineSum  = {1'b0, fineAcc} + {1'b0, stepFine};
    wrap     = fineSum[FINE_W];
    // on wrap the extra modulo shortens the effective period to 2^FINE_W - modulo
    fineNext = wrap ? (fineSum[FINE_W-1:0] + modulo) : fineSum[FINE_W-1:0];
    strobe.clear = reset;
    strobe.carry = wrap & ~reset;
  end

  always_ff @(posedge clk) begin
    if (reset) fineAcc <= '0;
    else       fineAcc <= fineNext;
  end
endmodule

// File: rtl/phase_acc_coarse.sv
module phase_acc_coarse
  import phase_acc_pkg::*;
#(
  parameter int COARSE_W = 20
) (
  input  logic                clk,
  input  acc_strobe_t         strobe,
  input  logic [COARSE_W-1:0] stepCoarse,
  output logic [COARSE_W-1:0] phase
);
  logic [COARSE_W-1:0] carryIn;

  always_comb carryIn = {{(COARSE_W-1){1'b0}}, strobe.carry};

  always_ff @(posedge clk) begin
    if (strobe.clear) phase <= '0;
    else              phase <= phase + stepCoarse + carryIn;
  end
endmodule

// File: rtl/dual_mod_phase_acc.sv
module dual_mod_phase_acc
  import phase_acc_pkg::*;
#(
  parameter int COARSE_W = 20,
  parameter int FINE_W   = 12
) (
  input  logic                clk,
  input  logic                reset,
  input  logic [COARSE_W-1:0] stepCoarse,
  input  logic [FINE_W-1:0]   stepFine,
  input  logic [FINE_W-1:0]   modulo,
  output logic [COARSE_W-1:0] phase
);
  localparam int WORD_W = COARSE_W + FINE_W;  // full host step word

  acc_strobe_t       strobe;
  logic [FINE_W-1:0] fineAcc;

  phase_acc_fine #(.FINE_W(FINE_W)) uFine (
    .clk      (clk),
    .reset    (reset),
    .stepFine (stepFine),
    .modulo   (modulo),
    .strobe   (strobe),
    .fineAcc  (fineAcc)
  );

  phase_acc_coarse #(.COARSE_W(COARSE_W)) uCoarse (
    .clk        (clk),
    .strobe     (strobe),
    .stepCoarse (stepCoarse),
    .phase      (phase)
  );

  initial begin
    if (WORD_W < 2) $error("step word too narrow");
  end
endmodule

// File: rtl/dual_mod_phase_acc_chk.sv
module dual_mod_phase_acc_chk #(
  parameter int COARSE_W = 20,
  parameter int FINE_W   = 12
) (
  input logic                clk,
  input logic                reset,
  input logic [COARSE_W-1:0] stepCoarse,
  input logic [FINE_W-1:0]   stepFine,
  input logic [FINE_W-1:0]   modulo,
  input logic [COARSE_W-1:0] phase,
  input logic                carry,
  input logic [FINE_W-1:0]   fineAcc
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (reset)
    $past(reset) |-> (phase == '0 && fineAcc == '0));

  // R3
  carry_adds_one_chk: assert property (@(posedge clk) disable iff (reset)
    carry |=> (COARSE_W'(phase - $past(phase) - $past(stepCoarse)) == COARSE_W'(1)));

  // R3
  no_carry_plain_chk: assert property (@(posedge clk) disable iff (reset)
    !carry |=> (COARSE_W'(phase - $past(phase) - $past(stepCoarse)) == '0));

  // R3
  fine_wrap_chk: assert property (@(posedge clk) disable iff (reset)
    carry |=> (fineAcc == FINE_W'($past(fineAcc) + $past(stepFine) + $past(modulo))));

  // R3
  fine_step_chk: assert property (@(posedge clk) disable iff (reset)
    !carry |=> (fineAcc == FINE_W'($past(fineAcc) + $past(stepFine))));

  // R6
  step_stable_chk: assert property (@(posedge clk) disable iff (reset)
    (stepCoarse == '0 && !carry) |=> $stable(phase));
endmodule

bind dual_mod_phase_acc dual_mod_phase_acc_chk #(
  .COARSE_W (COARSE_W),
  .FINE_W   (FINE_W)
) chk (
  .clk        (clk),
  .reset      (reset),
  .stepCoarse (stepCoarse),
  .stepFine   (stepFine),
  .modulo     (modulo),
  .phase      (phase),
  .carry      (strobe.carry),
  .fineAcc    (fineAcc)
);

// File: tb/tb_dual_mod_phase_acc.sv
`timescale 1ns/1ps
module tb_dual_mod_phase_acc;
  localparam int CW = 20;
  localparam int FW = 12;
  localparam longint CMOD = 64'd1 << CW;
  localparam longint FMOD = 64'd1 << FW;

  logic          clk = 1'b0;
  logic          reset = 1'b1;
  logic [CW-1:0] stepCoarse = '0;
  logic [FW-1:0] stepFine = '0;
  logic [FW-1:0] modulo = '0;
  logic [CW-1:0] phase;

  int checks = 0;
  int fails  = 0;
  longint mFine = 0;
  longint mCoarse = 0;

  always #2.5 clk = ~clk;

  dual_mod_phase_acc dut (
    .clk(clk), .reset(reset), .stepCoarse(stepCoarse),
    .stepFine(stepFine), .modulo(modulo), .phase(phase)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: phase actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural model of one clock edge
  task automatic modelEdge();
    longint s;
    longint c;
    if (reset) begin
      mFine = 0; mCoarse = 0;
    end else begin
      c = 0;
      s = mFine + longint'(stepFine);
      if (s >= FMOD) begin
        s = (s - FMOD + longint'(modulo)) % FMOD;
        c = 1;
      end
      mFine = s;
      mCoarse = (mCoarse + longint'(stepCoarse) + c) % CMOD;
    end
  endtask

  task automatic tick(input string tag);
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    check(tag, longint'(phase), mCoarse);
  endtask

  task automatic doReset();
    reset = 1'b1;
    tick("R8 reset");
    reset = 1'b0;
  endtask

  task automatic ratioTest(input string tag, input int unsigned sc, input int unsigned sf,
                           input int unsigned md, input int q);
    longint p0;
    doReset();
    stepCoarse = CW'(sc); stepFine = FW'(sf); modulo = FW'(md);
    for (int i = 0; i < 40; i++) tick(tag);
    p0 = longint'(phase);
    for (int i = 0; i < q; i++) tick(tag);
    check({tag, " period return"}, longint'(phase), p0);
  endtask

  initial begin
    #(200000 * 5);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    longint word;
    @(negedge clk);
    // R1: reset state after several edges with stepping inputs present
    stepCoarse = 20'h12345; stepFine = 12'hABC;
    for (int i = 0; i < 3; i++) tick("R1 reset hold");
    check("R1 phase zero", longint'(phase), 0);

    // R7: one-cycle latency, no fine wrap on first edge
    reset = 1'b0;
    stepCoarse = 20'h00321; stepFine = 12'h010; modulo = '0;
    tick("R7 latency");
    check("R7 first edge equals step", longint'(phase), 64'h321);

    // R2: modulo zero acts as 32-bit binary accumulator
    doReset();
    stepCoarse = 20'h12345; stepFine = 12'h678; modulo = '0;
    word = 64'h12345678;
    for (int n = 1; n <= 60; n++) begin
      tick("R2 binary");
      check("R2 closed form", longint'(phase), ((longint'(n) * word) % (64'd1 << 32)) >> FW);
    end

    // R3: fine wrap with modulo adds carry on the same edge
    doReset();
    stepCoarse = '0; stepFine = 12'd4000; modulo = 12'd100;
    tick("R3 no wrap");
    check("R3 before wrap", longint'(phase), 0);
    tick("R3 wrap");
    check("R3 carry into coarse", longint'(phase), 1);
    tick("R3 wrap again");
    check("R3 second carry", longint'(phase), 2);
    for (int i = 0; i < 20; i++) tick("R3 run");

    // R4: coarse wraps modulo 2^20
    doReset();
    stepCoarse = 20'hFFFFF; stepFine = 12'hFFF; modulo = 12'd7;
    for (int i = 0; i < 30; i++) tick("R4 wrap");
    stepCoarse = 20'h80001; stepFine = 12'h800; modulo = 12'd0;
    for (int i = 0; i < 30; i++) tick("R4 wrap half");

    // R6: live changes keep phase, take effect next edge
    stepCoarse = 20'h00100; stepFine = 12'h001; modulo = 12'd3;
    for (int i = 0; i < 10; i++) tick("R6 change");
    stepCoarse = 20'h0; stepFine = 12'h0;
    tick("R6 hold");
    tick("R6 hold");

    // R5: exact rational frequencies
    ratioTest("R5 7/33", 222425, 7 * 124, 4, 33);
    ratioTest("R5 8/11", 762600, 8 * 372, 4, 11);
    ratioTest("R5 9/13", 725937, 3 * 314, 14, 13);

    // R8: reset wins over stepping mid-run
    stepCoarse = 20'h0ABCD; stepFine = 12'hFFF; modulo = 12'd1;
    for (int i = 0; i < 5; i++) tick("R8 run");
    reset = 1'b1;
    tick("R8 reset priority");
    check("R8 cleared", longint'(phase), 0);
    reset = 1'b0;
    for (int i = 0; i < 5; i++) tick("R8 resume");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule